// File: doc/BRIEF.md
# Timer Clock Prescaler and Divider Tree

This block turns one peripheral clock into five count-enable tick streams, one per timer channel. Two 8-bit prescalers divide the peripheral clock. Channels 0 and 1 use the first prescaler, and channels 2 to 4 use the second. Behind each prescaler, every channel has its own power-of-two divider and its own source selector. The selector passes either the divided tick or the rising edges of an external timer clock. Channels 0 and 1 watch external input 0, and channels 2 to 4 watch external input 1. Each external input is synchronised and edge-detected inside the block.

Software sets the block up through a write port with two words. Word 0 holds both prescaler settings. Word 1 holds one select slot per channel. Every tick output is a registered, single-cycle enable in the peripheral clock domain. A timer counter advances by one on each cycle in which its tick is high.

Top module: `tmr_clk_tree`

## Requirements
- R1: While `rst_n` is low, every tick output is 0. After reset, both prescaler settings and all select codes are 0. The first tick on every channel therefore comes 2 clock edges after reset is released, and further ticks follow every 2 cycles.
- R2: A write with `wr_addr`=0 loads prescaler 0 from `wr_data[7:0]` and prescaler 1 from `wr_data[15:8]`. A prescaler with setting P produces one step every P+1 cycles.
- R3: A write with `wr_addr`=1 loads channel c's 3-bit select code from `wr_data[4c+2:4c]`. Codes 0, 1, 2 and 3 give one tick every 2, 4, 8 or 16 prescaler steps. The tick period is therefore (2<<code)*(P+1) cycles.
- R4: Channels 0 and 1 count steps of prescaler 0. Channels 2, 3 and 4 count steps of prescaler 1.
- R5: Select codes 4, 5, 6 and 7 all route the external clock to the channel. The channel then gives exactly one tick per rising edge of that input. Channels 0 and 1 use `ext_clk[0]`, and channels 2 to 4 use `ext_clk[1]`.
- R6: An external rising edge that arrives between two clock edges shows up as a tick after the third following clock edge, and not earlier.
- R7: A prescaler write restarts both prescalers and all dividers. The first tick of a divided channel then comes exactly (2<<code)*(P+1) clock edges after the write edge.
- R8: No tick is output in the cycle that follows any write edge.
- R9: No tick output is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 1 | 0 = prescaler word, 1 = select word |
| wr_data | input | 32 | Configuration write data |
| ext_clk | input | 2 | Asynchronous external timer clocks |
| tick | output | 5 | Per-channel single-cycle count enables |

## Verification
The bench sweeps the divide codes across all five channels by rotating the codes among them. It combines these with several pairs of prescaler settings. For each run it checks both the delay from the restarting write to the first tick and the tick period. A design that restarts the counters out of phase, or that maps a channel to the wrong prescaler, gets the first-tick delay wrong. A design that decodes the 2<<code divider off by one gets the period wrong. On the external path, the bench counts ticks against the edges it drove, using every external code from 4 to 7, and it checks the edge latency cycle by cycle. A missing synchroniser stage, a level detector in place of an edge detector, or a channel wired to the wrong input would each show up as a wrong count or a tick in the wrong cycle.

// File: rtl/tmr_clk_pkg.sv
// Shared constants and helpers for the timer clock tree.
// Assumes 3-bit select codes packed in 4-bit slots, and two channel groups.
package tmr_clk_pkg;
    localparam int SEL_W  = 3;   // select code width
    localparam int SLOT_W = 4;   // slot pitch in the select word
    localparam int NGRP   = 2;   // prescaler / external clock groups
    localparam int DCNT_W = 4;   // divider counter, up to divide by 16

    typedef logic [SEL_W-1:0] sel_t;

    // Codes 4..7 pick the external clock: the top bit alone decides.
    function automatic logic sel_is_ext(sel_t s);
        return s[SEL_W-1];
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: gives one step pulse every SETTING+1 cycles.
// Assumes `restart` is asserted on the edge that loads a new setting.
module tmr_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PS_W-1:0] setting,
    output logic            step_o
);
    logic [PS_W-1:0] cnt;

    // Step when the count reaches the setting.
    assign step_o = (cnt == setting);

    // Count from zero up to the setting, then wrap; restart clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (step_o)  cnt <= '0;
        else              cnt <= cnt + PS_W'(1);
    end
endmodule

// File: rtl/tmr_divider.sv
// Channel divider: one pulse per 2<<code prescaler steps.
// Assumes code is 0..3; the pulse is combinational and is registered by the caller.
module tmr_divider
    import tmr_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       step,
    input  logic [1:0] code,
    output logic       tick_o
);
    logic [DCNT_W-1:0] cnt;
    logic [DCNT_W:0]   span;
    logic [DCNT_W-1:0] last;

    // Terminal count for the selected division ratio.
    always_comb begin
        span = (DCNT_W+1)'(2) << code;
        last = DCNT_W'(span - (DCNT_W+1)'(1));
    end

    assign tick_o = step && (cnt == last);

    // Advance on each prescaler step and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (step)    cnt <= (cnt == last) ? '0 : cnt + DCNT_W'(1);
    end
endmodule

// File: rtl/tmr_edge_sync.sv
// Brings an asynchronous clock into the clk domain with two flops.
// A third flop turns each rising edge into a single-cycle pulse.
// Assumes the input stays high and low for at least one clk period each.
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [2:0] stg;

    // Shift the input through the synchroniser and the edge history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[1:0], async_in};
    end

    assign rise_o = stg[1] & ~stg[2];
endmodule

// File: rtl/tmr_clk_tree.sv
// Clock tree for a five-channel timer: configuration words, two prescalers,
// per-channel dividers and source selectors, and registered tick outputs.
// Assumes channels below SPLIT belong to group 0 and the rest to group 1.
module tmr_clk_tree
    import tmr_clk_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int SPLIT  = 2,
    parameter int PS_W   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NGRP-1:0]   ext_clk,
    output logic [NCH-1:0]    tick
);
    logic [NGRP-1:0][PS_W-1:0] ps_cfg;
    sel_t [NCH-1:0]            sel_cfg;
    logic [NGRP-1:0]           ps_tick;
    logic [NGRP-1:0]           ext_rise;
    logic [NCH-1:0]            div_tick;
    logic                      ps_restart;
    logic                      unused_wr_bits;

    assign ps_restart     = wr_en && !wr_addr;
    assign unused_wr_bits = ^wr_data;

    // Configuration words: prescaler settings and per-channel select slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_cfg  <= '0;
            sel_cfg <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < NGRP; g++)
                if (!wr_addr) ps_cfg[g] <= wr_data[PS_W*g +: PS_W];
            for (int c = 0; c < NCH; c++)
                if (wr_addr) sel_cfg[c] <= wr_data[SLOT_W*c +: SEL_W];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        tmr_prescaler #(.PS_W(PS_W)) u_ps (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(ps_restart),
            .setting(ps_cfg[g]),
            .step_o (ps_tick[g])
        );
        tmr_edge_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(ext_clk[g]),
            .rise_o  (ext_rise[g])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = (c < SPLIT) ? 0 : 1;

        tmr_divider u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(wr_en),
            .step   (ps_tick[GRP]),
            .code   (sel_cfg[c][1:0]),
            .tick_o (div_tick[c])
        );

        // Register the selected source and hold it low in the cycle after a write.
        always_ff @(posedge clk) begin
            if (!rst_n) tick[c] <= 1'b0;
            else        tick[c] <= !wr_en &&
                                   (sel_is_ext(sel_cfg[c]) ? ext_rise[GRP] : div_tick[c]);
        end
    end
endmodule

// File: rtl/tmr_clk_tree_chk.sv
// Property checker for tmr_clk_tree, bound into every instance.
// Assumes the group split used by the design it is bound to.
module tmr_clk_tree_chk
    import tmr_clk_pkg::*;
#(
    parameter int NCH   = 5,
    parameter int SPLIT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [NCH-1:0]  tick,
    input sel_t [NCH-1:0]  sel,
    input logic [NGRP-1:0] ps_tick,
    input logic [NGRP-1:0] ext_rise
);
    // R1: no ticks come out while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> tick == '0);

    // R8: outputs stay quiet in the cycle after a write edge
    a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tick == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        localparam int GRP = (c < SPLIT) ? 0 : 1;

        // R9: a tick is never high in two consecutive cycles
        a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |=> !tick[c]);

        // R5: in external mode, a tick follows an edge detected on the channel's group input
        a_r5_ext_source: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && sel_is_ext(sel[c]) && !$past(wr_en)) |-> $past(ext_rise[GRP]));

        // R4: in divided mode, a tick follows a step of the channel's own prescaler
        a_r4_div_source: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && !sel_is_ext(sel[c]) && !$past(wr_en)) |-> $past(ps_tick[GRP]));
    end
endmodule

bind tmr_clk_tree tmr_clk_tree_chk #(.NCH(NCH), .SPLIT(SPLIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .tick    (tick),
    .sel     (sel_cfg),
    .ps_tick (ps_tick),
    .ext_rise(ext_rise)
);

// File: tb/tmr_clk_tree_bench.sv
`timescale 1ns/1ps
module tmr_clk_tree_bench;
    localparam int NCH = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           wr_addr = 1'b0;
    logic [31:0]    wr_data = '0;
    logic [1:0]     ext_clk = '0;
    logic [NCH-1:0] tick;

    int n_chk = 0;
    int n_err = 0;
    int t1 [NCH];
    int t2 [NCH];

    always #2.5 clk = ~clk;

    tmr_clk_tree u_tmr_clk_tree (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clk(ext_clk), .tick(tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge just after the write edge.
    task automatic wr(input bit a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(tick == '0, "R8 tick after write", int'(tick), 0);
    endtask

    // Record the first two tick positions per channel, in edges from the start point.
    task automatic measure(input int maxk);
        for (int c = 0; c < NCH; c++) begin t1[c] = -1; t2[c] = -1; end
        for (int k = 1; k <= maxk; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++)
                if (tick[c]) begin
                    if (t1[c] < 0) t1[c] = k;
                    else if (t2[c] < 0) t2[c] = k;
                end
        end
    endtask

    initial begin
        #(5ns * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int p0v [4] = '{0, 1, 2, 5};
        int p1v [4] = '{3, 0, 7, 4};
        int r0, r1;
        int c0 [NCH];

        // R1: quiet in reset, then divide by 2 from the reset state
        repeat (4) begin
            @(negedge clk);
            check(tick == '0, "R1 tick in reset", int'(tick), 0);
        end
        rst_n = 1'b1;
        measure(6);
        for (int c = 0; c < NCH; c++) begin
            check(t1[c] == 2, "R1 first tick after reset", t1[c], 2);
            check(t2[c] - t1[c] == 2, "R1 period after reset", t2[c] - t1[c], 2);
        end

        // R2 R3 R4 R7: sweep prescaler pairs and rotate codes over channels
        for (int pi = 0; pi < 4; pi++) begin
            for (int r = 0; r < 4; r++) begin
                logic [31:0] sw;
                sw = '0;
                for (int c = 0; c < NCH; c++) sw[4*c +: 4] = 4'((c + r) % 4);
                wr(1'b1, sw);
                wr(1'b0, {16'h0, 8'(p1v[pi]), 8'(p0v[pi])});
                measure(2 * 16 * 8 + 8);
                for (int c = 0; c < NCH; c++) begin
                    int p, e;
                    p = (c < 2) ? p0v[pi] : p1v[pi];
                    e = (2 << ((c + r) % 4)) * (p + 1);
                    check(t1[c] == e, "R7/R2/R4 first tick after restart", t1[c], e);
                    check(t2[c] - t1[c] == e, "R3/R2/R4 tick period", t2[c] - t1[c], e);
                end
            end
        end

        // R5: external selection with codes 4..7
        wr(1'b1, 32'h0006_4574);
        repeat (6) @(negedge clk);
        // R6: edge latency of three clock edges
        ext_clk[0] = 1'b1;
        @(negedge clk);
        check(tick[0] == 1'b0, "R6 tick one edge after input rise", int'(tick[0]), 0);
        @(negedge clk);
        check(tick[0] == 1'b0, "R6 tick two edges after input rise", int'(tick[0]), 0);
        @(negedge clk);
        check(tick[0] == 1'b1, "R6 tick three edges after input rise", int'(tick[0]), 1);
        check(tick[1] == 1'b1, "R5 ch1 follows ext0", int'(tick[1]), 1);
        check(tick[4:2] == 3'b000, "R5 ch2-4 ignore ext0", int'(tick[4:2]), 0);
        repeat (3) @(negedge clk);
        ext_clk[0] = 1'b0;
        repeat (6) @(negedge clk);

        // R5: count ticks against driven edges on both inputs
        r0 = 0; r1 = 0;
        for (int c = 0; c < NCH; c++) c0[c] = 0;
        for (int i = 0; i < 130; i++) begin
            logic [1:0] nx;
            nx[0] = (i < 120) ? ((i / 3) % 2 == 1) : 1'b0;
            nx[1] = (i < 120) ? ((i / 5) % 2 == 1) : 1'b0;
            if (nx[0] && !ext_clk[0]) r0++;
            if (nx[1] && !ext_clk[1]) r1++;
            ext_clk = nx;
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (tick[c]) c0[c]++;
        end
        for (int c = 0; c < NCH; c++) begin
            int e;
            e = (c < 2) ? r0 : r1;
            check(c0[c] == e, "R5 ext tick count", c0[c], e);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule